// File: doc/BRIEF.md
# Window-Regulated Switching Sequencer

This block drives the two gate enables of a synchronous DC/DC converter: a low-side N switch that ramps the inductor current up, and a high-side P switch that acts as a synchronous rectifier while the current ramps down. It has no error amplifier and no ramp comparator. Two comparator flags report whether the output sits above the high border or below the low border of a narrow regulation window. The sequencer samples those flags once per switching cycle, when the ramp-down phase ends. It then keeps the same pattern, or moves a saturating current-level register one step up or down. The ramp-up length is loaded into a down-counter from that level.

In PWM operation every period is exactly `PERIOD` controller clocks long. An undershoot adds a one-time stretch of the next ramp-up. An over-current flag cuts the running ramp short without moving the period boundary. In PFM operation the sequencer waits while the output is above the high border, then fires single pulses at one level above the last PWM level. It ends each ramp-down when the inductor current reaches zero. One idle clock with both switches off separates every hand-over between the switches.

Top module: `window_switch_seq`

## Requirements
- R1: A synchronous active-low reset turns both switches off, clears `cycle_done` and sets the level to `LVL_MIN`. The first PWM cycle after reset therefore ramps up for `BASE_ON + LVL_MIN*STEP_ON` clocks (5 by default).
- R2: In PWM mode each period is exactly `PERIOD` (22) clocks. `cycle_done` is high for one clock at the start of each period, in that period's first dead-time clock.
- R3: A period runs in this order: one dead clock, N on, one dead clock, P on. N and P are never on together, and neither turns on in the clock after the other was on.
- R4: While neither window flag is sampled high, every PWM period repeats the same pattern. N is on for `BASE_ON + lvl*STEP_ON` clocks and P for the rest of the period less the two dead clocks.
- R5: When `below_lo` is high at the period boundary, the level rises by one. The next ramp-up alone is `BOOST_ON` (6) clocks longer, and the period after that uses the plain length for the new level.
- R6: When `above_hi` alone is high at the period boundary, the level falls by one, which shortens the next ramp-up by `STEP_ON`.
- R7: The level saturates and never leaves the range `LVL_MIN`..`LVL_MAX` (1..6).
- R8: When both window flags are high at the boundary, `below_lo` wins and the level rises with the boost.
- R9: `over_cur` seen during ramp-up turns N off at the next edge. The sequence then goes to the dead clock and the P phase, and the PWM period length is unchanged.
- R10: `over_cur` seen during a PWM ramp-down turns P off at the next edge. Both switches then stay off until the period boundary, including when this happens on the last clock of the period.
- R11: `zero_cur` has no effect in PWM mode: P stays on for its full phase.
- R12: In PFM mode (`pfm_mode` high, taken at a cycle boundary) the sequencer stays idle while `above_hi` is high. It starts a pulse once `above_hi` is low, with ramp-up length `BASE_ON + min(lvl+1, LVL_MAX)*STEP_ON`. The window flags do not change the level in PFM.
- R13: In a PFM pulse, `zero_cur` (or `over_cur`) during the ramp-down turns P off at the next edge, with `cycle_done` high in that clock, and the sequencer returns to idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| above_hi | input | 1 | Output is above the high window border |
| below_lo | input | 1 | Output is below the low window border |
| over_cur | input | 1 | Switch current exceeds its limit |
| zero_cur | input | 1 | Inductor current has reached zero |
| pfm_mode | input | 1 | 1 selects PFM, 0 selects PWM |
| n_on | output | 1 | Low-side N switch enable |
| p_on | output | 1 | High-side P switch enable |
| cycle_done | output | 1 | One-clock strobe after each ramp-down ends |

## Verification
Two pairs of functions can fall on the same clock. In the first, the period-boundary decision meets an over-current cut-off: the bench raises `over_cur` on the very last P clock of a PWM period. It then judges that the period is still 22 clocks, that P drops and that `cycle_done` comes where it normally would. In the second, both window flags are raised across a whole period. The bench judges that the next ramp-up has the boosted length of a level rise rather than the shorter length of a fall.

// File: rtl/window_switch_seq.sv
`timescale 1ns/1ps
module window_switch_seq #(
  parameter int PERIOD   = 22,
  parameter int LVL_W    = 3,
  parameter int LVL_MIN  = 1,
  parameter int LVL_MAX  = 6,
  parameter int BASE_ON  = 4,
  parameter int STEP_ON  = 1,
  parameter int BOOST_ON = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic above_hi,
  input  logic below_lo,
  input  logic over_cur,
  input  logic zero_cur,
  input  logic pfm_mode,
  output logic n_on,
  output logic p_on,
  output logic cycle_done
);
  localparam int TON_MAX = BASE_ON + LVL_MAX * STEP_ON + BOOST_ON;
  localparam int CW = $clog2(TON_MAX + 1);
  localparam int PW = $clog2(PERIOD);
  localparam logic [LVL_W-1:0] LMIN = LVL_W'(LVL_MIN);
  localparam logic [LVL_W-1:0] LMAX = LVL_W'(LVL_MAX);

  typedef enum logic [2:0] {IDLE, DT_A, RAMP_UP, DT_B, RAMP_DN, HOLD} phase_t;

  phase_t           st;
  logic [PW-1:0]    pc;
  logic [CW-1:0]    cnt;
  logic [LVL_W-1:0] lvl, lvl_up, lvl_dn, lvl_nx;
  logic             run_pfm, pwm_close;

  assign lvl_up    = (lvl >= LMAX) ? LMAX : lvl + 1'b1;
  assign lvl_dn    = (lvl <= LMIN) ? LMIN : lvl - 1'b1;
  assign lvl_nx    = below_lo ? lvl_up : (above_hi ? lvl_dn : lvl);
  assign pwm_close = !run_pfm && (pc == PW'(PERIOD - 1)) && (st == RAMP_DN || st == HOLD);

  assign n_on = (st == RAMP_UP);
  assign p_on = (st == RAMP_DN);

  function automatic logic [CW-1:0] ton_m1(input logic [LVL_W-1:0] l, input logic boost);
    ton_m1 = CW'(BASE_ON - 1) + CW'(l) * CW'(STEP_ON) + (boost ? CW'(BOOST_ON) : '0);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= IDLE;
      pc         <= '0;
      cnt        <= '0;
      lvl        <= LMIN;
      run_pfm    <= 1'b0;
      cycle_done <= 1'b0;
    end else begin
      cycle_done <= 1'b0;
      pc         <= pc + 1'b1;
      case (st)
        IDLE:
          if (!pfm_mode || !above_hi) begin
            st      <= DT_A;
            pc      <= '0;
            run_pfm <= pfm_mode;
            cnt     <= pfm_mode ? ton_m1(lvl_up, 1'b0) : ton_m1(lvl, 1'b0);
          end
        DT_A: st <= RAMP_UP;
        RAMP_UP:
          if (over_cur || cnt == '0) st <= DT_B;
          else cnt <= cnt - 1'b1;
        DT_B: st <= RAMP_DN;
        RAMP_DN:
          if (run_pfm) begin
            if (zero_cur || over_cur) begin
              st         <= IDLE;
              cycle_done <= 1'b1;
            end
          end else if (over_cur) begin
            st <= HOLD;
          end
        HOLD: ;
        default: st <= IDLE;
      endcase
      if (pwm_close) begin
        cycle_done <= 1'b1;
        lvl        <= lvl_nx;
        if (pfm_mode) begin
          st <= IDLE;
        end else begin
          st      <= DT_A;
          pc      <= '0;
          run_pfm <= 1'b0;
          cnt     <= ton_m1(lvl_nx, below_lo);
        end
      end
    end
  end
endmodule

// File: rtl/window_switch_seq_chk.sv
`timescale 1ns/1ps
module window_switch_seq_chk #(
  parameter int LVL_W   = 3,
  parameter int LVL_MIN = 1,
  parameter int LVL_MAX = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             n_on,
  input logic             p_on,
  input logic             cycle_done,
  input logic             over_cur,
  input logic             zero_cur,
  input logic             run_pfm,
  input logic [LVL_W-1:0] lvl
);
  // R3
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n) !(n_on && p_on));
  // R3
  dead_after_n_chk: assert property (@(posedge clk) disable iff (!rst_n) n_on |=> !p_on);
  // R3
  dead_after_p_chk: assert property (@(posedge clk) disable iff (!rst_n) p_on |=> !n_on);
  // R2
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n) cycle_done |=> !cycle_done);
  // R9
  oc_cut_up_chk: assert property (@(posedge clk) disable iff (!rst_n) (n_on && over_cur) |=> !n_on);
  // R10
  oc_cut_dn_chk: assert property (@(posedge clk) disable iff (!rst_n) (p_on && over_cur) |=> !p_on);
  // R13
  zero_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
                                  (p_on && run_pfm && zero_cur) |=> (!p_on && cycle_done));
  // R7
  lvl_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
                                  (lvl >= LVL_W'(LVL_MIN)) && (lvl <= LVL_W'(LVL_MAX)));
endmodule

bind window_switch_seq window_switch_seq_chk #(
  .LVL_W(LVL_W), .LVL_MIN(LVL_MIN), .LVL_MAX(LVL_MAX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .n_on(n_on), .p_on(p_on), .cycle_done(cycle_done),
  .over_cur(over_cur), .zero_cur(zero_cur), .run_pfm(run_pfm), .lvl(lvl)
);

// File: tb/window_switch_seq_tb.sv
`timescale 1ns/1ps
module window_switch_seq_tb;
  localparam int PER = 22, BASE = 4, STEP = 1, BOOST = 6, LMIN = 1, LMAX = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic above_hi = 1'b0, below_lo = 1'b0, over_cur = 1'b0, zero_cur = 1'b0, pfm_mode = 1'b0;
  logic n_on, p_on, cycle_done;

  int checks = 0, errors = 0;
  int lvl_m = LMIN;
  bit boost_m = 1'b0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  window_switch_seq u_dut (
    .clk(clk), .rst_n(rst_n), .above_hi(above_hi), .below_lo(below_lo),
    .over_cur(over_cur), .zero_cur(zero_cur), .pfm_mode(pfm_mode),
    .n_on(n_on), .p_on(p_on), .cycle_done(cycle_done)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic wait_done();
    int n = 0;
    do begin tick(); n++; end while (!cycle_done && n < 200);
    chk("R2", "strobe seen", int'(cycle_done), 1);
  endtask

  // one PWM period, started right after a cycle_done sample
  task automatic run_cycle(input string tag, input int oc_mode, input int oc_k);
    int n = 0, p = 0, len = 0, k = oc_k;
    bit inj = 1'b0;
    int exp_t = BASE + lvl_m * STEP + (boost_m ? BOOST : 0);
    if (k < 0) k = PER - 2 - exp_t;
    do begin
      tick();
      len++;
      if (inj) begin
        inj = 1'b0;
        over_cur = 1'b0;
        if (oc_mode == 1) chk(tag, "N cut by over-current", int'(n_on), 0);
        else              chk(tag, "P cut by over-current", int'(p_on), 0);
      end
      if (n_on) n++;
      if (p_on) p++;
      if (oc_mode == 1 && n_on && n == k) begin over_cur = 1'b1; inj = 1'b1; end
      if (oc_mode == 2 && p_on && p == k) begin over_cur = 1'b1; inj = 1'b1; end
    end while (!cycle_done && len < 100);
    chk(tag, "period length", len, PER);
    chk(tag, "N clocks", n, (oc_mode == 1) ? k : exp_t);
    chk(tag, "P clocks", p, (oc_mode == 1) ? PER - 2 - k : (oc_mode == 2) ? k : PER - 2 - exp_t);
    if (below_lo) begin
      lvl_m = (lvl_m + 1 > LMAX) ? LMAX : lvl_m + 1;
      boost_m = 1'b1;
    end else begin
      if (above_hi) lvl_m = (lvl_m - 1 < LMIN) ? LMIN : lvl_m - 1;
      boost_m = 1'b0;
    end
  endtask

  task automatic t_reset();
    repeat (3) tick();
    chk("R1", "n_on in reset", int'(n_on), 0);
    chk("R1", "p_on in reset", int'(p_on), 0);
    chk("R1", "cycle_done in reset", int'(cycle_done), 0);
    rst_n = 1'b1;
    wait_done();
  endtask

  task automatic t_steady();
    run_cycle("R4", 0, 0);
    run_cycle("R4", 0, 0);
  endtask

  task automatic t_under();
    below_lo = 1'b1;
    run_cycle("R5", 0, 0);
    below_lo = 1'b0;
    run_cycle("R5", 0, 0);
    run_cycle("R5", 0, 0);
  endtask

  task automatic t_sat();
    below_lo = 1'b1;
    for (int i = 0; i < 7; i++) run_cycle("R7", 0, 0);
    below_lo = 1'b0;
    run_cycle("R7", 0, 0);
    chk("R7", "model at max", lvl_m, LMAX);
    run_cycle("R7", 0, 0);
    above_hi = 1'b1;
    run_cycle("R6", 0, 0);
    run_cycle("R6", 0, 0);
    for (int i = 0; i < 6; i++) run_cycle("R7", 0, 0);
    above_hi = 1'b0;
    run_cycle("R7", 0, 0);
    chk("R7", "model at min", lvl_m, LMIN);
  endtask

  task automatic t_both();
    above_hi = 1'b1;
    below_lo = 1'b1;
    run_cycle("R8", 0, 0);
    above_hi = 1'b0;
    below_lo = 1'b0;
    run_cycle("R8", 0, 0);
    run_cycle("R8", 0, 0);
  endtask

  task automatic t_oc();
    run_cycle("R9", 1, 2);
    run_cycle("R10", 2, 3);
    run_cycle("R10", 2, -1);
    run_cycle("R9", 0, 0);
  endtask

  task automatic t_zero_pwm();
    zero_cur = 1'b1;
    run_cycle("R11", 0, 0);
    zero_cur = 1'b0;
  endtask

  task automatic t_pfm();
    int n = 0, w = 0, exp_t;
    int lvl_keep;
    pfm_mode = 1'b1;
    above_hi = 1'b1;
    run_cycle("R12", 0, 0);
    lvl_keep = lvl_m;
    below_lo = 1'b1;
    for (int i = 0; i < 20; i++) begin
      tick();
      if (n_on || p_on || cycle_done) n++;
    end
    chk("R12", "activity while above high border", n, 0);
    below_lo = 1'b0;
    above_hi = 1'b0;
    exp_t = BASE + ((lvl_m + 1 > LMAX) ? LMAX : lvl_m + 1) * STEP;
    do begin tick(); w++; end while (!n_on && w < 10);
    n = 1;
    forever begin
      tick();
      if (!n_on) break;
      n++;
    end
    chk("R12", "PFM ramp-up clocks", n, exp_t);
    chk("R3", "dead clock after N", int'(p_on), 0);
    tick();
    chk("R13", "P on in PFM", int'(p_on), 1);
    above_hi = 1'b1;
    repeat (3) tick();
    chk("R13", "P held until zero current", int'(p_on), 1);
    zero_cur = 1'b1;
    tick();
    zero_cur = 1'b0;
    chk("R13", "P off after zero current", int'(p_on), 0);
    chk("R13", "strobe after PFM ramp-down", int'(cycle_done), 1);
    n = 0;
    for (int i = 0; i < 10; i++) begin
      tick();
      if (n_on || p_on || cycle_done) n++;
    end
    chk("R13", "idle after PFM pulse", n, 0);
    pfm_mode = 1'b0;
    above_hi = 1'b0;
    wait_done();
    chk("R12", "level kept through PFM", lvl_m, lvl_keep);
    run_cycle("R12", 0, 0);
  endtask

  task automatic t_reset_mid();
    int w = 0;
    below_lo = 1'b1;
    run_cycle("R5", 0, 0);
    below_lo = 1'b0;
    do begin tick(); w++; end while (!n_on && w < 30);
    rst_n = 1'b0;
    tick();
    chk("R1", "n_on after mid-run reset", int'(n_on), 0);
    chk("R1", "p_on after mid-run reset", int'(p_on), 0);
    tick();
    rst_n = 1'b1;
    lvl_m = LMIN;
    boost_m = 1'b0;
    wait_done();
    run_cycle("R1", 0, 0);
  endtask

  initial begin
    t_reset();
    t_steady();
    t_under();
    t_sat();
    t_both();
    t_oc();
    t_zero_pwm();
    t_pfm();
    t_reset_mid();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1ms;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule